// File: doc/BRIEF.md
# Palette and Gamma Lookup Unit

This unit sits in a display pixel pipeline just ahead of the dithering stage. It holds three 256-entry by 8-bit colour tables, one each for red, green and blue. The same storage serves two purposes. In palette mode the three tables act together as one 24-bit indexed palette, addressed by a low-depth pixel code. In gamma mode each table is a separate transfer curve that remaps one colour component of a full-colour pixel.

A host loads entries through a simple write port: one address and one 32-bit word update all three tables in the same cycle. The operating mode, the pixel depth and a monochrome flag are presented on configuration inputs. They are captured only on a frame-boundary strobe, so a frame is always processed with one setting. Palette mode at direct-colour depths passes pixels through unchanged. Every path has the same one-cycle latency, so the output pixel and its valid flag stay aligned whatever the mode.

Top module: `pixel_lut_unit`

## Requirements
- R1: When `rst` is high, `out_valid` and `out_rgb` are 0 on the following cycle. Reset also selects palette mode, colour (not monochrome) and depth code 3 (8 bits per pixel) until the next frame strobe.
- R2: `out_valid` equals `pix_valid` of the previous cycle. `out_rgb` is 0 in every cycle where `out_valid` is 0.
- R3: A host write with `wr_en` high stores `wr_data[23:16]` in the red table, `wr_data[15:8]` in the green table and `wr_data[7:0]` in the blue table, all at `wr_addr`. `wr_data[31:24]` has no effect.
- R4: In palette mode, depth codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel. The index is the low 1, 2, 4 or 8 bits of `pix_data`, zero-extended, so these depths reach only entries 0..1, 0..3, 0..15 or 0..255. All other `pix_data` bits have no effect.
- R5: In colour palette mode, the output for index i is {red[i], green[i], blue[i]}, with red in bits 23:16 and blue in bits 7:0.
- R6: In monochrome palette mode (`cfg_mono` = 1) at an indexed depth, the blue-table byte at the index (the gray value, entry bits 7:0) appears on all three output bytes.
- R7: In palette mode, depth codes 4, 5, 6 (12, 16, 24 bits per pixel) and 7 (treated as 24) bypass the tables: `out_rgb` equals the input `pix_data`, and the monochrome flag has no effect.
- R8: In gamma mode (`cfg_gamma` = 1), `pix_data[23:16]` indexes the red table, `[15:8]` the green table and `[7:0]` the blue table, and the three results form the output. Depth and monochrome settings have no effect in this mode.
- R9: The configuration inputs are captured on a rising clock edge where `frame_sync` is high. A pixel presented in that same cycle still uses the old setting. Changes to the configuration inputs without the strobe have no effect.
- R10: When a pixel read and a host write reach the same table address in the same cycle, the pixel gets the entry's old contents. The new contents are seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame-boundary strobe that captures the configuration |
| cfg_gamma | input | 1 | 1 = gamma mode, 0 = palette mode |
| cfg_mono | input | 1 | 1 = monochrome palette output |
| cfg_depth | input | 3 | Depth code: 0..3 = 1/2/4/8 bpp, 4/5/6 = 12/16/24 bpp, 7 = 24 bpp |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_data | input | 24 | Pixel: index in the low bits, or R[23:16] G[15:8] B[7:0] |
| wr_en | input | 1 | Host table write enable |
| wr_addr | input | 8 | Host table entry address |
| wr_data | input | 32 | Host entry word; bits 31:24 ignored |
| out_valid | output | 1 | Output pixel qualifier |
| out_rgb | output | 24 | Output pixel R[23:16] G[15:8] B[7:0] |

## Verification
A wrong captured configuration shows up on the first valid output pixel after the strobe that should have set it. A frozen or early configuration register also shows in the cycle where the inputs differ from the active setting. Corrupt table contents or a wrong index mask appear one cycle after any pixel that addresses the affected entry, as a mismatched byte in the matching channel. A misordered write/read in a collision cycle gives the new value one cycle too early, so the bench deliberately aims pixels at the address being written.

// File: rtl/lut_pkg.sv
package lut_pkg;

  localparam int NCH = 3;

  typedef enum logic [2:0] {
    DEPTH_1   = 3'd0,
    DEPTH_2   = 3'd1,
    DEPTH_4   = 3'd2,
    DEPTH_8   = 3'd3,
    DEPTH_12  = 3'd4,
    DEPTH_16  = 3'd5,
    DEPTH_24  = 3'd6,
    DEPTH_24X = 3'd7
  } depth_e;

  typedef struct packed {
    logic   gamma;
    logic   mono;
    depth_e depth;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{gamma: 1'b0, mono: 1'b0, depth: DEPTH_8};

  function automatic logic is_direct(depth_e d);
    return (d == DEPTH_12) || (d == DEPTH_16) || (d == DEPTH_24) || (d == DEPTH_24X);
  endfunction

endpackage

// File: rtl/lut_cfg.sv
module lut_cfg
  import lut_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_sync,
  input  cfg_t cfg_req,
  output cfg_t cfg_act
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_act <= CFG_RESET;
    end else if (frame_sync) begin
      cfg_act <= cfg_req;
    end
  end

  // R9: the active setting moves only after a strobe
  a_r9_cfg_frame_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(frame_sync)) |-> $stable(cfg_act));

endmodule

// File: rtl/lut_index.sv
module lut_index
  import lut_pkg::*;
#(
  parameter int COMP_W = 8
) (
  input  logic                           use_gamma,
  input  depth_e                         depth,
  input  logic [NCH*COMP_W-1:0]          pix,
  output logic [NCH-1:0][COMP_W-1:0]     idx
);

  localparam int TOP_BITS = COMP_W;

  logic [COMP_W-1:0] pal_mask;
  logic [COMP_W-1:0] pal_idx;

  always_comb begin
    int bits;
    bits = 1 << int'(depth);
    if (bits > TOP_BITS) bits = TOP_BITS;
    pal_mask = '0;
    for (int b = 0; b < COMP_W; b++) begin
      if (b < bits) pal_mask[b] = 1'b1;
    end
  end

  assign pal_idx = pix[COMP_W-1:0] & pal_mask;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_sel
      assign idx[c] = use_gamma ? pix[c*COMP_W +: COMP_W] : pal_idx;
    end
  endgenerate

endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [COMP_W-1:0] waddr,
  input  logic [COMP_W-1:0] wdata,
  input  logic [COMP_W-1:0] raddr,
  output logic [COMP_W-1:0] rdata
);

  localparam int DEPTH = 1 << COMP_W;

  logic [COMP_W-1:0] mem [DEPTH];

  // read-first port: a same-address read sees the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lut_outsel.sv
module lut_outsel
  import lut_pkg::*;
#(
  parameter int COMP_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pix_valid,
  input  logic [NCH*COMP_W-1:0]      pix,
  input  cfg_t                       cfg,
  input  logic [NCH-1:0][COMP_W-1:0] rd,
  output logic                       out_valid,
  output logic [NCH*COMP_W-1:0]      out_rgb
);

  logic                  valid_q;
  logic                  bypass_q;
  logic                  mono_q;
  logic [NCH*COMP_W-1:0] pix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      bypass_q <= 1'b0;
      mono_q   <= 1'b0;
      pix_q    <= '0;
    end else begin
      valid_q  <= pix_valid;
      bypass_q <= !cfg.gamma && is_direct(cfg.depth);
      mono_q   <= !cfg.gamma && cfg.mono && !is_direct(cfg.depth);
      pix_q    <= pix;
    end
  end

  always_comb begin
    if (!valid_q) begin
      out_rgb = '0;
    end else if (bypass_q) begin
      out_rgb = pix_q;
    end else if (mono_q) begin
      out_rgb = {NCH{rd[0]}};
    end else begin
      out_rgb = rd;
    end
  end

  assign out_valid = valid_q;

endmodule

// File: rtl/pixel_lut_unit.sv
module pixel_lut_unit
  import lut_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int HOST_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_sync,
  input  logic                  cfg_gamma,
  input  logic                  cfg_mono,
  input  logic [2:0]            cfg_depth,
  input  logic                  pix_valid,
  input  logic [3*COMP_W-1:0]   pix_data,
  input  logic                  wr_en,
  input  logic [COMP_W-1:0]     wr_addr,
  input  logic [HOST_W-1:0]     wr_data,
  output logic                  out_valid,
  output logic [3*COMP_W-1:0]   out_rgb
);

  localparam int PIX_W = NCH * COMP_W;

  cfg_t cfg_req;
  cfg_t cfg_act;
  logic [NCH-1:0][COMP_W-1:0] rd_idx;
  logic [NCH-1:0][COMP_W-1:0] rd_data;
  logic unused_host_pad;

  assign unused_host_pad = ^wr_data[HOST_W-1:PIX_W];
  assign cfg_req = '{gamma: cfg_gamma, mono: cfg_mono, depth: depth_e'(cfg_depth)};

  lut_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .cfg_req    (cfg_req),
    .cfg_act    (cfg_act)
  );

  lut_index #(.COMP_W(COMP_W)) u_idx (
    .use_gamma (cfg_act.gamma),
    .depth     (cfg_act.depth),
    .pix       (pix_data),
    .idx       (rd_idx)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      lut_bank #(.COMP_W(COMP_W)) u_bank (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data[c*COMP_W +: COMP_W]),
        .raddr (rd_idx[c]),
        .rdata (rd_data[c])
      );
    end
  endgenerate

  lut_outsel #(.COMP_W(COMP_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix       (pix_data),
    .cfg       (cfg_act),
    .rd        (rd_data),
    .out_valid (out_valid),
    .out_rgb   (out_rgb)
  );

  // R2: output qualifier trails the input by one cycle
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(pix_valid)));

  // R2: idle output is zero
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_rgb == '0));

  // R7: direct-colour palette depths pass the pixel through
  a_r7_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pix_valid) && !$past(cfg_act.gamma) && $past(is_direct(cfg_act.depth)))
      |-> (out_rgb == $past(pix_data)));

  // R6: monochrome palette output repeats one byte
  a_r6_mono_spread: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pix_valid) && !$past(cfg_act.gamma) && $past(cfg_act.mono)
      && !$past(is_direct(cfg_act.depth)))
      |-> ((out_rgb[PIX_W-1 -: COMP_W] == out_rgb[COMP_W-1:0])
        && (out_rgb[2*COMP_W-1 -: COMP_W] == out_rgb[COMP_W-1:0])));

endmodule

// File: tb/pixel_lut_unit_test.sv
module pixel_lut_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_sync = 1'b0;
  logic        cfg_gamma = 1'b0;
  logic        cfg_mono = 1'b0;
  logic [2:0]  cfg_depth = 3'd3;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pixel_lut_unit uut (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .cfg_gamma(cfg_gamma),
    .cfg_mono(cfg_mono), .cfg_depth(cfg_depth), .pix_valid(pix_valid),
    .pix_data(pix_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  // behavioural reference state
  logic [7:0] tr [256];
  logic [7:0] tg [256];
  logic [7:0] tb [256];
  bit         m_gamma = 0;
  bit         m_mono = 0;
  int         m_depth = 3;
  bit          vq[$];
  logic [23:0] rq[$];
  string       tq[$];

  initial begin
    for (int i = 0; i < 256; i++) begin
      tr[i] = '0; tg[i] = '0; tb[i] = '0;
    end
  end

  always @(posedge clk) begin
    bit          ev;
    logic [23:0] er;
    string       et;
    int          ix;
    bit          hit;
    ev = 0; er = '0; et = "R2"; hit = 0;
    if (rst) begin
      m_gamma = 0; m_mono = 0; m_depth = 3;
      et = "R1";
    end else begin
      ev = pix_valid;
      if (pix_valid) begin
        if (m_gamma) begin
          er = {tr[pix_data[23:16]], tg[pix_data[15:8]], tb[pix_data[7:0]]};
          et = "R8";
          hit = wr_en && (wr_addr == pix_data[23:16] || wr_addr == pix_data[15:8]
                          || wr_addr == pix_data[7:0]);
        end else if (m_depth >= 4) begin
          er = pix_data;
          et = "R7";
        end else begin
          ix = int'(pix_data[7:0]) & ((1 << (1 << m_depth)) - 1);
          if (m_mono) begin
            er = {tb[ix], tb[ix], tb[ix]};
            et = "R6";
          end else begin
            er = {tr[ix], tg[ix], tb[ix]};
            et = (m_depth == 3) ? "R3/R5" : "R4";
          end
          hit = wr_en && (int'(wr_addr) == ix);
        end
        if (hit) et = "R10";
        if (cfg_gamma != m_gamma || cfg_mono != m_mono || int'(cfg_depth) != m_depth)
          et = "R9";
      end
      if (frame_sync) begin
        m_gamma = cfg_gamma; m_mono = cfg_mono; m_depth = int'(cfg_depth);
      end
      if (wr_en) begin
        tr[wr_addr] = wr_data[23:16];
        tg[wr_addr] = wr_data[15:8];
        tb[wr_addr] = wr_data[7:0];
      end
    end
    vq.push_back(ev); rq.push_back(er); tq.push_back(et);
  end

  always @(negedge clk) begin
    bit          ev;
    logic [23:0] er;
    string       et;
    if (vq.size() > 0 && !done) begin
      ev = vq.pop_front(); er = rq.pop_front(); et = tq.pop_front();
      checks++;
      if (out_valid !== ev || out_rgb !== er) begin
        errors++;
        $display("FAIL %s: valid=%0b rgb=%06h expected valid=%0b rgb=%06h",
                 et, out_valid, out_rgb, ev, er);
      end
    end
  end

  task automatic set_cfg(input bit g, input bit m, input int d);
    cfg_gamma = g; cfg_mono = m; cfg_depth = d[2:0];
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic burst(input int n);
    for (int k = 0; k < n; k++) begin
      pix_valid = ($urandom % 4) != 0;
      pix_data = 24'($urandom);
      @(negedge clk);
    end
    pix_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R3: fill all tables; top byte is junk and must be dropped
    for (int i = 0; i < 256; i++) begin
      wr_en = 1'b1; wr_addr = 8'(i);
      wr_data = {8'hA5, 8'(i * 7 + 3), 8'(i ^ 8'h5a), 8'(255 - i)};
      @(negedge clk);
    end
    wr_en = 1'b0;
    burst(30);                                   // R1 defaults, R5
    for (int d = 0; d < 4; d++) begin set_cfg(0, 0, d); burst(40); end  // R4
    set_cfg(0, 1, 3); burst(30);                 // R6
    set_cfg(0, 1, 1); burst(30);
    for (int d = 4; d < 8; d++) begin set_cfg(0, 0, d); burst(20); end  // R7
    set_cfg(0, 1, 5); burst(20);
    set_cfg(1, 0, 3); burst(40);                 // R8
    set_cfg(1, 1, 0); burst(40);
    // R9: inputs change without strobe
    cfg_gamma = 0; cfg_depth = 3'd0; cfg_mono = 1;
    burst(30);
    pix_valid = 1'b1; pix_data = 24'h123456; frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0; pix_valid = 1'b0;
    burst(20);
    // R10: collisions in palette mode
    set_cfg(0, 0, 3);
    for (int k = 0; k < 32; k++) begin
      pix_valid = 1'b1; pix_data = {16'h0, 8'(k * 5)};
      wr_en = 1'b1; wr_addr = 8'(k * 5); wr_data = 32'($urandom);
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
    end
    pix_valid = 1'b0;
    // R10: collisions in gamma mode
    set_cfg(1, 0, 6);
    for (int k = 0; k < 32; k++) begin
      pix_valid = 1'b1; pix_data = 24'($urandom);
      wr_en = 1'b1; wr_addr = pix_data[15:8]; wr_data = 32'($urandom);
      @(negedge clk);
    end
    pix_valid = 1'b0; wr_en = 1'b0;
    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      pix_valid = ($urandom % 3) != 0;
      pix_data = 24'($urandom);
      wr_en = ($urandom % 4) == 0;
      wr_addr = 8'($urandom);
      wr_data = 32'($urandom);
      frame_sync = ($urandom % 25) == 0;
      cfg_gamma = 1'($urandom); cfg_mono = 1'($urandom); cfg_depth = 3'($urandom);
      @(negedge clk);
    end
    pix_valid = 1'b0; wr_en = 1'b0; frame_sync = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R2: watchdog expired, actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule